// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Programmable Triggers

This block collects a bank of external interrupt request lines, conditions each one according to a per-source trigger mode, ranks the requests that qualify by a per-source priority level, and raises a single interrupt line toward a processor. The processor reads a status word that names the winning source and its level. When that word reports no pending request, software knows the line was spurious.

Each request line passes through a synchronizer. Level-triggered sources count as pending only while the line sits at its active level. Edge-triggered sources latch a sticky flag on the selected edge, and only an explicit clear command written by software removes that flag. A source with level zero never competes. A global threshold removes every source whose level does not exceed it, and a master enable gates the whole controller. All configuration is reached over a simple word-addressed register port with combinational read data.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, the status word reads 0x0001_0000 and `irq_o` is 0.
- R2: Word addresses are: 0 enable, 1 mode word low, 2 mode word high, 8 to 15 level words 0 to 7, 16 threshold, 17 edge-clear command, 18 status. Enable, mode, level and threshold words keep and read back all 32 written bits. The command and any unmapped address read 0. A write to the status address changes nothing.
- R3: Source n takes its 2-bit trigger mode from mode word n/16 at bits (n mod 16)*2+1:(n mod 16)*2. Mode 0 is active-low level and mode 1 is active-high level. A level source is pending only while its synchronized input is at the active value, and nothing is latched.
- R4: Mode 2 latches a pending flag on a falling edge and mode 3 on a rising edge. The flag stays set until it is cleared, even after the input returns. Switching the source to a level mode discards the flag.
- R5: Source n takes its level from the low 3 bits of the byte at bit offset (n/16)*16 + (n mod 2)*8 in level word (n mod 16)/2. Level 0 keeps the source out of arbitration.
- R6: A pending source competes only when its level is strictly greater than the low 3 bits of the threshold word.
- R7: Among competing sources, the highest level wins. On a tie, the lower source number wins.
- R8: A write to the edge-clear address with bit 8 set clears the latched flag of the source numbered by bits 4:0. Without bit 8, the write has no effect. An edge detected in the same cycle as its clear leaves the flag set.
- R9: `irq_o` and a valid status word appear only while bit 0 of the enable word is 1.
- R10: Status bits 4:0 hold the winning source and bits 10:8 hold its level. Bit 16 is 0 when a request is valid. With no valid request, bit 16 is 1 and every other bit is 0.
- R11: After an input change that lands before clock edge k, the status and `irq_o` are unchanged up to edge k+1 and reflect the change after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | External request lines, asynchronous |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two events can land in the same cycle: a software clear of an edge-latched flag, and a fresh qualifying edge on that same source. The bench produces this overlap by timing the clear write so that it is sampled at exactly the edge on which the newly detected edge sets the flag. The status word must then still name that source. A second run moves the write one cycle later and expects the flag to be gone. Random sequences of configuration writes, pin changes and clear commands are checked against a bench model, which catches other interactions between the two functions.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int REG_W        = 32;
   localparam int MODE_FIELD_W = 2;
   localparam int LVL_SLOT_W   = 8;
   localparam int SRC_PER_MODE = REG_W / MODE_FIELD_W;
   localparam int LVL_WORDS    = 8;
   localparam int CLR_IDX_W    = 5;
   localparam int CLR_GO_BIT   = 8;
   localparam int ST_LVL_LSB   = 8;
   localparam int ST_NONE_BIT  = 16;

   typedef enum logic [4:0] {
      RA_ENABLE = 5'd0,
      RA_MODE0  = 5'd1,
      RA_MODE1  = 5'd2,
      RA_LVL0   = 5'd8,
      RA_THRESH = 5'd16,
      RA_ECLR   = 5'd17,
      RA_STATUS = 5'd18
   } reg_addr_e;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_RISE = 2'd3
   } trig_mode_e;

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int LVL_W   = 3,
   parameter int ADDR_W  = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [REG_W-1:0]           wdata,
   input  logic                       we,
   input  logic [REG_W-1:0]           status_word,
   output logic [REG_W-1:0]           rdata,
   output logic                       ctrl_en,
   output logic [NUM_SRC*2-1:0]       mode_flat,
   output logic [NUM_SRC*LVL_W-1:0]   lvl_flat,
   output logic [LVL_W-1:0]           thresh,
   output logic [NUM_SRC-1:0]         clr_vec
);

   localparam int MODE_WORDS = 2;

   logic [REG_W-1:0] en_w;
   logic [REG_W-1:0] thr_w;
   logic [REG_W-1:0] mode_w [MODE_WORDS];
   logic [REG_W-1:0] lvl_w  [LVL_WORDS];

   logic hit_en, hit_thr, hit_lvl, hit_clr;
   logic [MODE_WORDS-1:0] hit_mode;
   logic [2:0] lvl_sel;

   assign hit_en      = we && (addr == ADDR_W'(RA_ENABLE));
   assign hit_thr     = we && (addr == ADDR_W'(RA_THRESH));
   assign hit_mode[0] = we && (addr == ADDR_W'(RA_MODE0));
   assign hit_mode[1] = we && (addr == ADDR_W'(RA_MODE1));
   assign hit_lvl     = we && (addr[ADDR_W-1:3] == (ADDR_W-3)'(RA_LVL0 >> 3));
   assign hit_clr     = we && (addr == ADDR_W'(RA_ECLR)) && wdata[CLR_GO_BIT];
   assign lvl_sel     = addr[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_w  <= '0;
         thr_w <= '0;
         for (int m = 0; m < MODE_WORDS; m++) mode_w[m] <= '0;
         for (int w = 0; w < LVL_WORDS; w++)  lvl_w[w]  <= '0;
      end else begin
         if (hit_en)  en_w  <= wdata;
         if (hit_thr) thr_w <= wdata;
         for (int m = 0; m < MODE_WORDS; m++)
            if (hit_mode[m]) mode_w[m] <= wdata;
         if (hit_lvl) lvl_w[lvl_sel] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr[ADDR_W-1:3] == (ADDR_W-3)'(RA_LVL0 >> 3)) begin
         rdata = lvl_w[lvl_sel];
      end else begin
         case (addr)
            ADDR_W'(RA_ENABLE): rdata = en_w;
            ADDR_W'(RA_MODE0):  rdata = mode_w[0];
            ADDR_W'(RA_MODE1):  rdata = mode_w[1];
            ADDR_W'(RA_THRESH): rdata = thr_w;
            ADDR_W'(RA_STATUS): rdata = status_word;
            default:            rdata = '0;
         endcase
      end
   end

   assign ctrl_en = en_w[0];
   assign thresh  = thr_w[LVL_W-1:0];

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_field
      localparam int MW  = n / SRC_PER_MODE;
      localparam int MO  = (n % SRC_PER_MODE) * MODE_FIELD_W;
      localparam int LWD = (n % 16) / 2;
      localparam int LO  = (n / 16) * 16 + (n % 2) * LVL_SLOT_W;
      assign mode_flat[n*2 +: 2]         = mode_w[MW][MO +: 2];
      assign lvl_flat[n*LVL_W +: LVL_W]  = lvl_w[LWD][LO +: LVL_W];
      assign clr_vec[n] = hit_clr && (wdata[CLR_IDX_W-1:0] == CLR_IDX_W'(n));
   end

   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_vec)) else $error("clear hits more than one source"); // R8
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == ADDR_W'(RA_ENABLE)) |=> $stable(ctrl_en))
      else $error("enable changed without a write"); // R9

endmodule

// File: rtl/prio_irq_detect.sv
module prio_irq_detect
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   irq_in,
   input  logic [NUM_SRC*2-1:0] mode_flat,
   input  logic [NUM_SRC-1:0]   clr_vec,
   output logic [NUM_SRC-1:0]   pend
);

   logic [NUM_SRC-1:0] s_now;
   logic [NUM_SRC-1:0] s_prev;
   logic [NUM_SRC-1:0] lvl_q;
   logic [NUM_SRC-1:0] edge_q;
   logic [NUM_SRC-1:0] is_edge;
   logic [NUM_SRC-1:0] act_hi;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign s_now = irq_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][NUM_SRC-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else begin
            chain[0] <= irq_in;
            for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
         end
      end
      assign s_now = chain[SYNC_STAGES-1];
   end

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      logic hit;
      assign is_edge[n] = mode_flat[n*2+1];
      assign act_hi[n]  = mode_flat[n*2];
      assign hit = act_hi[n] ? (s_now[n] & ~s_prev[n]) : (~s_now[n] & s_prev[n]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_prev[n] <= 1'b0;
            lvl_q[n]  <= 1'b0;
            edge_q[n] <= 1'b0;
         end else begin
            s_prev[n] <= s_now[n];
            lvl_q[n]  <= act_hi[n] ? s_now[n] : ~s_now[n];
            if (!is_edge[n])     edge_q[n] <= 1'b0;
            else if (hit)        edge_q[n] <= 1'b1;
            else if (clr_vec[n]) edge_q[n] <= 1'b0;
         end
      end

      assign pend[n] = is_edge[n] ? edge_q[n] : lvl_q[n];

      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[n] && !clr_vec[n] && is_edge[n]) |=> edge_q[n])
         else $error("edge flag lost without clear"); // R4
      AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         !is_edge[n] |=> !edge_q[n])
         else $error("edge flag held in level mode"); // R3
   end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int LVL_W   = 3,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       pend,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
   input  logic [LVL_W-1:0]         thresh,
   output logic                     found,
   output logic [IDX_W-1:0]         win_idx,
   output logic [LVL_W-1:0]         win_lvl
);

   logic [LVL_W-1:0]   lvl_a [NUM_SRC];
   logic [NUM_SRC-1:0] elig;

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
      assign lvl_a[n] = lvl_flat[n*LVL_W +: LVL_W];
      assign elig[n]  = pend[n] && (lvl_a[n] != '0) && (lvl_a[n] > thresh);
   end

   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!found || lvl_a[i] >= win_lvl)) begin
            found   = 1'b1;
            win_lvl = lvl_a[i];
            win_idx = IDX_W'(i);
         end
      end
   end

   AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> pend[win_idx]) else $error("winner not pending"); // R7
   AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (win_lvl != '0)) else $error("level 0 winner"); // R5
   AST_WIN_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (win_lvl > thresh)) else $error("winner under threshold"); // R6

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int LVL_W       = 3,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_we,
   output logic [31:0]        bus_rdata,
   output logic               irq_o
);

   localparam int IDX_W = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 2..32");
   end
   if (LVL_W < 1 || LVL_W > 3) begin : g_bad_lvl
      $error("LVL_W must lie in 1..3");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic                     ctrl_en;
   logic [NUM_SRC*2-1:0]     mode_flat;
   logic [NUM_SRC*LVL_W-1:0] lvl_flat;
   logic [LVL_W-1:0]         thresh;
   logic [NUM_SRC-1:0]       clr_vec;
   logic [NUM_SRC-1:0]       pend;
   logic                     found;
   logic [IDX_W-1:0]         win_idx;
   logic [LVL_W-1:0]         win_lvl;
   logic [31:0]              status_word;

   prio_irq_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
      .status_word(status_word), .rdata(bus_rdata), .ctrl_en(ctrl_en),
      .mode_flat(mode_flat), .lvl_flat(lvl_flat), .thresh(thresh), .clr_vec(clr_vec)
   );

   prio_irq_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_flat(mode_flat),
      .clr_vec(clr_vec), .pend(pend)
   );

   prio_irq_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend(pend), .lvl_flat(lvl_flat), .thresh(thresh),
      .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   always_comb begin
      status_word = '0;
      if (ctrl_en && found) begin
         status_word[ST_LVL_LSB +: LVL_W] = win_lvl;
         status_word[0 +: IDX_W]          = win_idx;
      end else begin
         status_word[ST_NONE_BIT] = 1'b1;
      end
   end

   assign irq_o = ctrl_en && found;

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ctrl_en) else $error("irq while disabled"); // R9
   AST_IRQ_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o != status_word[ST_NONE_BIT]) else $error("flag and irq disagree"); // R10

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [31:0] m_en, m_thr;
   logic [31:0] m_mode [2];
   logic [31:0] m_lvl  [8];
   logic [31:0] m_ef;

   always #10 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [1:0] mode_of(int n);
      return m_mode[n/16][(n%16)*2 +: 2];
   endfunction

   function automatic logic [2:0] lvl_of(int n);
      return m_lvl[(n%16)/2][(n/16)*16 + (n%2)*8 +: 3];
   endfunction

   function automatic logic [31:0] exp_status();
      logic [2:0] best = 0;
      int idx = -1;
      for (int n = 0; n < 32; n++) begin
         logic [1:0] md = mode_of(n);
         logic p = md[1] ? m_ef[n] : (md[0] ? irq_in[n] : ~irq_in[n]);
         logic [2:0] lv = lvl_of(n);
         if (p && lv != 0 && lv > m_thr[2:0] && (idx < 0 || lv > best)) begin
            best = lv; idx = n;
         end
      end
      if (m_en[0] && idx >= 0) return {21'd0, best, 3'd0, 5'(idx)};
      return 32'h0001_0000;
   endfunction

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      if (a == 5'd0) m_en = d;
      else if (a == 5'd16) m_thr = d;
      else if (a == 5'd1 || a == 5'd2) begin
         m_mode[a-1] = d;
         for (int n = 0; n < 32; n++) if (!mode_of(n)[1]) m_ef[n] = 1'b0;
      end else if (a >= 5'd8 && a <= 5'd15) m_lvl[a-8] = d;
      else if (a == 5'd17 && d[8]) m_ef[d[4:0]] = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pins(input logic [31:0] v);
      for (int n = 0; n < 32; n++) begin
         logic [1:0] md = mode_of(n);
         if (md == 2'd3 && !irq_in[n] && v[n]) m_ef[n] = 1'b1;
         if (md == 2'd2 && irq_in[n] && !v[n]) m_ef[n] = 1'b1;
      end
      @(negedge clk);
      irq_in = v;
   endtask

   task automatic chk_status(input string tag);
      logic [31:0] s;
      rd(5'd18, s);
      chk(s, exp_status(), tag);
      chk({31'd0, irq_o}, {31'd0, ~exp_status()[16]}, tag);
   endtask

   task automatic clear_cfg();
      wr(5'd0, 0); wr(5'd16, 0); wr(5'd1, 0); wr(5'd2, 0);
      for (int w = 0; w < 8; w++) wr(5'(8 + w), 0);
      pins(32'h0); settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      m_en = 0; m_thr = 0; m_mode[0] = 0; m_mode[1] = 0; m_ef = 0;
      for (int w = 0; w < 8; w++) m_lvl[w] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 19; a++) begin
         rd(5'(a), d);
         chk(d, (a == 18) ? 32'h0001_0000 : 32'h0, "R1 reset read");
      end
      chk({31'd0, irq_o}, 32'd0, "R1 irq after reset");

      // R2 readback, command and unmapped reads, status write ignored
      wr(5'd9, 32'hDEAD_BEE8); rd(5'd9, d); chk(d, 32'hDEAD_BEE8, "R2 level word");
      wr(5'd2, 32'h1234_5678); rd(5'd2, d); chk(d, 32'h1234_5678, "R2 mode word");
      wr(5'd16, 32'hA5A5_0000); rd(5'd16, d); chk(d, 32'hA5A5_0000, "R2 thresh word");
      wr(5'd17, 32'h0000_0103); rd(5'd17, d); chk(d, 32'h0, "R2 command reads 0");
      rd(5'd5, d); chk(d, 32'h0, "R2 unmapped");
      wr(5'd18, 32'hFFFF_FFFF); rd(5'd18, d); chk(d, 32'h0001_0000, "R2 status write ignored");
      clear_cfg();

      // R5 layout: source 17 lives in word 0 byte 3; source 6 in word 3 byte 0
      wr(5'd0, 1);
      wr(5'd8, 32'h0500_0000); settle();          // source 17 level 5, mode low, pin 0
      chk_status("R5 source17 layout");
      wr(5'd8, 32'h0000_0000); wr(5'd11, 32'h0000_0003); settle();
      chk_status("R5 source6 layout");
      chk(exp_status(), 32'h0000_0306, "R5 model sanity");
      wr(5'd11, 32'h0000_0008); settle();         // only upper bits set: level 0
      chk_status("R5 level0 disabled");

      // R3 level modes
      clear_cfg(); wr(5'd0, 1);
      wr(5'd9, 32'h0000_0004);                    // source 2 level 4
      wr(5'd1, 32'h0000_0010); settle();          // source 2 active high, pin 0
      chk_status("R3 high mode idle");
      pins(32'h4); settle(); chk_status("R3 high mode active");
      pins(32'h0); settle(); chk_status("R3 level not latched");

      // R4 edge modes
      wr(5'd1, 32'h0000_0030);                    // rising
      pins(32'h4); settle(); chk_status("R4 rising latch");
      pins(32'h0); settle(); chk_status("R4 latch held");
      wr(5'd17, 32'h0000_0102); settle(); chk_status("R4 cleared");
      wr(5'd1, 32'h0000_0020);                    // falling
      pins(32'h4); settle(); chk_status("R4 rise ignored in falling");
      pins(32'h0); settle(); chk_status("R4 falling latch");
      wr(5'd1, 32'h0000_0000); settle(); chk_status("R4 level switch drops flag");

      // R8 command without go bit, then overlap with fresh edge
      wr(5'd1, 32'h0000_0030);
      pins(32'h4); settle();
      wr(5'd17, 32'h0000_0002); settle(); chk_status("R8 no go bit");
      wr(5'd17, 32'h0000_0102); pins(32'h0); settle();
      @(negedge clk); irq_in = 32'h4;             // rising edge before edge k
      @(negedge clk);                             // after k
      @(negedge clk); bus_addr = 5'd17; bus_wdata = 32'h102; bus_we = 1'b1; // sampled at k+2
      @(negedge clk); bus_we = 1'b0;
      m_ef[2] = 1'b1; settle();
      chk_status("R8 clear and edge same cycle");
      chk(exp_status(), 32'h0000_0402, "R8 expected pending");
      pins(32'h0); settle();
      wr(5'd17, 32'h102);
      @(negedge clk); irq_in = 32'h4;
      @(negedge clk); @(negedge clk);
      @(negedge clk); bus_addr = 5'd17; bus_wdata = 32'h102; bus_we = 1'b1; // at k+3
      @(negedge clk); bus_we = 1'b0;
      m_ef[2] = 1'b0; settle();
      chk_status("R8 clear after edge");

      // R11 latency
      clear_cfg(); wr(5'd0, 1);
      wr(5'd9, 32'h0000_0500);                    // source 3 level 5
      wr(5'd1, 32'h0000_0040); settle();          // source 3 active high
      @(negedge clk); irq_in = 32'h8;
      @(negedge clk);                             // after k
      @(negedge clk); #1 chk(bus_rdata & 0, 0, "R11 dummy");
      bus_addr = 5'd18; #1 chk(bus_rdata, 32'h0001_0000, "R11 unchanged after k+1");
      @(negedge clk); #1 chk(bus_rdata, 32'h0000_0503, "R11 visible after k+2");
      chk({31'd0, irq_o}, 32'd1, "R11 irq after k+2");

      // R6 threshold, R7 tie, R9 enable
      clear_cfg(); wr(5'd0, 1);
      wr(5'd10, 32'h0006_0006);                   // sources 4 and 20 level 6
      wr(5'd8,  32'h0000_0600);                   // source 1 level 6
      settle(); chk_status("R7 tie lowest index");
      chk(exp_status(), 32'h0000_0601, "R7 expected winner 1");
      wr(5'd8, 32'h0000_0700); settle(); chk_status("R7 higher level wins");
      wr(5'd16, 32'h0000_0006); settle(); chk_status("R6 equal to threshold blocked");
      wr(5'd16, 32'h0000_0007); settle(); chk_status("R6 all blocked");
      wr(5'd0, 32'hFFFF_FFFE); settle(); chk_status("R9 bit0 clear disables");
      wr(5'd16, 0); settle(); chk_status("R9 still disabled");
      wr(5'd0, 32'h1); settle(); chk_status("R10 enabled format");

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 5);
         case (op)
            0: wr(5'(8 + $urandom_range(0, 7)), $urandom());
            1: wr(5'(1 + $urandom_range(0, 1)), $urandom());
            2: wr(5'd16, {$urandom_range(0, 255), 24'h0} | 32'($urandom_range(0, 7)));
            3: wr(5'd0, {$urandom_range(0, 3), 30'h0} | 32'($urandom_range(0, 5) != 0));
            4: pins(irq_in ^ $urandom() ^ $urandom());
            default: wr(5'd17, 32'($urandom_range(0, 1)) << 8 | 32'($urandom_range(0, 31)));
         endcase
         settle();
         chk_status("R7 R10 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule